// File: doc/BRIEF.md
# Dual-Period Watchdog Supervisor Timer

This block watches over a host processor using two timeouts that measure the same interval. The processor proves it is alive by giving a rising edge on a single strobe input. A rising edge restarts both timeouts from zero. The shorter timeout is the watchdog. When it runs out, the block pulls an active-low interrupt low and sets a sticky status flag. The longer timeout is the reset timer. When it runs out, the block drives an active-low reset pulse of programmable width.

Time is measured in ticks of a one-cycle `tick` pulse, one tick per millisecond. The period codes come from a configuration register outside this block. When the reset pulse ends, whether at the end of its programmed width or early on a strobe edge, both timeouts start again from zero. If the processor never strobes, the block keeps producing interrupts and resets. A synchronous `init` input returns the block to a clean state.

Top module: `dual_wd_supervisor`

## Requirements
- R1: A rising edge on `strobe` passes through a two-flop synchronizer. It sets the shared elapsed count to zero and clears a pending interrupt. Counting the clock edge that first samples `strobe` high as edge 1, the clear takes effect at edge 3. The count advances by one at each later edge that has `tick` high.
- R2: The watchdog period is selected by `wd_code`: 001=400, 010=800, 011=1600, 100=3200, 101=6400 ticks. When the elapsed count reaches that period, `irq_n` goes low and `wd_flag` goes high at the same edge. With `tick` high on every cycle, this is edge P+3 after a strobe (R1 numbering).
- R3: `irq_n` stays low until the next strobe rising edge clears it or until the reset pulse begins. `irq_n` is high whenever `rst_out_n` is low.
- R4: `wd_flag` stays high until `flag_clr` is sampled high. If an expiry and `flag_clr` fall on the same edge, the flag is set.
- R5: The reset period is selected by `ld_code`: 00=disabled, 01=1600, 10=3200, 11=6400 ticks. When the elapsed count reaches it, `rst_out_n` goes low.
- R6: The reset pulse width is selected by `rw_code`: 00=25, 01=50, 10=100, 11=200 ticks. A strobe rising edge during the pulse ends it at edge 3 (R1 numbering).
- R7: When `rst_out_n` returns high, both timeouts restart from zero. With `strobe` held low, the block repeats interrupts and reset pulses.
- R8: If the reset period is no longer than the watchdog period, the reset wins. `irq_n` never falls and `wd_flag` is not set.
- R9: While the synchronized `strobe` level is high, a watchdog expiry has no effect on `irq_n` or `wd_flag`. The reset path keeps working.
- R10: `wd_code` values 000, 110 and 111 turn the watchdog off. No interrupt is raised.
- R11: Without `tick` pulses, neither timeout advances.
- R12: With `init` high, the next edge zeroes the count, sets `irq_n` and `rst_out_n` high and clears `wd_flag`. After reset, `irq_n`=1, `rst_out_n`=1 and `wd_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-cycle time-base pulse (1 ms) |
| init | input | 1 | Synchronous active-high restart |
| strobe | input | 1 | Keep-alive strobe from the host; rising edge counts |
| wd_code | input | 3 | Watchdog period code |
| ld_code | input | 2 | Reset timer period code |
| rw_code | input | 2 | Reset pulse width code |
| flag_clr | input | 1 | Clears the watchdog status flag |
| irq_n | output | 1 | Active-low watchdog interrupt |
| rst_out_n | output | 1 | Active-low reset pulse |
| wd_flag | output | 1 | Sticky watchdog-timeout status |

## Verification
The checker assumes the period codes stay constant while a timeout runs. Its "code off" and "width bound" properties apply only on cycles where the code it reads has not changed since the previous edge. It also assumes `tick` is a clean pulse that counts once per sampled edge. The bench changes codes only while `init` is held high, so every checked interval begins from a known zero count. The bench drives `tick` either high on every cycle or held low. This makes the expected edge counts exact integers that follow from R1 and R2.

// File: rtl/wds_pkg.sv
package wds_pkg;
  typedef enum logic {
    PH_RUN = 1'b0,
    PH_RST = 1'b1
  } wds_phase_e;
endpackage

// File: rtl/wds_strobe_edge.sv
module wds_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic level,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= strobe;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign level = sync_q[SYNC_STAGES-1];
  assign rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/wds_period_map.sv
module wds_period_map #(
  parameter int WD_BASE = 400,
  parameter int LD_BASE = 1600,
  parameter int RW_BASE = 25,
  parameter int CW      = 13
) (
  input  logic [2:0]    wd_code,
  input  logic [1:0]    ld_code,
  input  logic [1:0]    rw_code,
  output logic          wd_en,
  output logic [CW-1:0] wd_per,
  output logic          ld_en,
  output logic [CW-1:0] ld_per,
  output logic [CW-1:0] rw_per
);
  always_comb begin
    wd_en  = (wd_code >= 3'd1) && (wd_code <= 3'd5);
    wd_per = CW'(WD_BASE);
    if (wd_en) wd_per = CW'(WD_BASE) << (wd_code - 3'd1);
    ld_en  = (ld_code != 2'd0);
    ld_per = CW'(LD_BASE);
    if (ld_en) ld_per = CW'(LD_BASE) << (ld_code - 2'd1);
    rw_per = CW'(RW_BASE) << rw_code;
  end
endmodule

// File: rtl/wds_elapsed.sv
module wds_elapsed #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = '1;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dual_wd_supervisor.sv
module dual_wd_supervisor #(
  parameter int WD_BASE     = 400,
  parameter int LD_BASE     = 1600,
  parameter int RW_BASE     = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       init,
  input  logic       strobe,
  input  logic [2:0] wd_code,
  input  logic [1:0] ld_code,
  input  logic [1:0] rw_code,
  input  logic       flag_clr,
  output logic       irq_n,
  output logic       rst_out_n,
  output logic       wd_flag
);
  import wds_pkg::*;

  localparam int WD_MAX = WD_BASE * 16;
  localparam int LD_MAX = LD_BASE * 4;
  localparam int RW_MAX = RW_BASE * 8;
  localparam int P_MAX  = (WD_MAX > LD_MAX) ? ((WD_MAX > RW_MAX) ? WD_MAX : RW_MAX)
                                            : ((LD_MAX > RW_MAX) ? LD_MAX : RW_MAX);
  localparam int CW     = $clog2(P_MAX + 1);

  logic          s_level, s_rise;
  logic          wd_en, ld_en;
  logic [CW-1:0] wd_per, ld_per, rw_per, elapsed;
  logic          cnt_clr;
  logic          wd_hit, ld_hit, rw_hit;

  wds_phase_e phase_q, phase_d;
  logic       irq_q, irq_d;
  logic       flag_q, flag_d;

  wds_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .level  (s_level),
    .rise   (s_rise)
  );

  wds_period_map #(.WD_BASE(WD_BASE), .LD_BASE(LD_BASE), .RW_BASE(RW_BASE), .CW(CW)) u_map (
    .wd_code (wd_code),
    .ld_code (ld_code),
    .rw_code (rw_code),
    .wd_en   (wd_en),
    .wd_per  (wd_per),
    .ld_en   (ld_en),
    .ld_per  (ld_per),
    .rw_per  (rw_per)
  );

  wds_elapsed #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (tick),
    .count (elapsed)
  );

  // A timeout expires on the tick that carries the count to its period.
  assign wd_hit = tick & wd_en & (elapsed == wd_per - 1'b1);
  assign ld_hit = tick & ld_en & (elapsed == ld_per - 1'b1);
  assign rw_hit = tick & (elapsed == rw_per - 1'b1);

  always_comb begin
    phase_d = phase_q;
    irq_d   = irq_q;
    flag_d  = flag_q & ~flag_clr;
    cnt_clr = 1'b0;
    if (init) begin
      phase_d = PH_RUN;
      irq_d   = 1'b0;
      flag_d  = 1'b0;
      cnt_clr = 1'b1;
    end else if (phase_q == PH_RUN) begin
      if (s_rise) begin
        cnt_clr = 1'b1;
        irq_d   = 1'b0;
      end else if (ld_hit) begin
        phase_d = PH_RST;
        cnt_clr = 1'b1;
        irq_d   = 1'b0;
      end else if (wd_hit && !s_level) begin
        irq_d  = 1'b1;
        flag_d = 1'b1;
      end
    end else begin
      if (s_rise || rw_hit) begin
        phase_d = PH_RUN;
        cnt_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      irq_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      irq_q   <= irq_d;
      flag_q  <= flag_d;
    end
  end

  assign irq_n     = ~irq_q;
  assign rst_out_n = (phase_q == PH_RUN);
  assign wd_flag   = flag_q;
endmodule

// File: rtl/wds_checker.sv
module wds_checker #(
  parameter int RW_BASE = 25
) (
  input logic       clk,
  input logic       rst_n,
  input logic       init,
  input logic       tick,
  input logic [2:0] wd_code,
  input logic [1:0] ld_code,
  input logic [1:0] rw_code,
  input logic       irq_n,
  input logic       rst_out_n,
  input logic       wd_flag
);
  logic [15:0] low_ticks_q;
  logic [15:0] width_lim;

  assign width_lim = 16'(RW_BASE) << rw_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_ticks_q <= '0;
    else if (rst_out_n)      low_ticks_q <= '0;
    else if (tick)           low_ticks_q <= low_ticks_q + 1'b1;
  end

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (irq_n && rst_out_n && !wd_flag)); // R12

  AST_RESET_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> irq_n); // R3

  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> wd_flag); // R2

  AST_WD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((wd_code == 3'd0 || wd_code >= 3'd6) && $stable(wd_code)) |-> !$fell(irq_n)); // R10

  AST_LD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_code == 2'd0 && $stable(ld_code)) |-> !$fell(rst_out_n)); // R5

  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out_n && $stable(rw_code)) |-> (low_ticks_q < width_lim)); // R6
endmodule

bind dual_wd_supervisor wds_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init      (init),
  .tick      (tick),
  .wd_code   (wd_code),
  .ld_code   (ld_code),
  .rw_code   (rw_code),
  .irq_n     (irq_n),
  .rst_out_n (rst_out_n),
  .wd_flag   (wd_flag)
);

// File: tb/sim_dual_wd_supervisor.sv
`timescale 1ns/1ps
module sim_dual_wd_supervisor;
  localparam int LAT = 3; // edges from strobe sample to clear, counting that edge

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       init = 1'b0;
  logic       strobe = 1'b0;
  logic [2:0] wd_code = 3'd0;
  logic [1:0] ld_code = 2'd0;
  logic [1:0] rw_code = 2'd0;
  logic       flag_clr = 1'b0;
  logic       irq_n, rst_out_n, wd_flag;

  int total = 0;
  int bad = 0;
  bit saw_irq_low;

  always #5 clk = ~clk;

  dual_wd_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .init(init), .strobe(strobe),
    .wd_code(wd_code), .ld_code(ld_code), .rw_code(rw_code), .flag_clr(flag_clr),
    .irq_n(irq_n), .rst_out_n(rst_out_n), .wd_flag(wd_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts edges until a condition holds at the following negedge.
  // what: 0 irq low, 1 irq high, 2 reset low, 3 reset high. Returns -1 on limit.
  task automatic count_until(input int what, input int limit, input bit pulse, output int n);
    bit hit;
    n = 0;
    hit = 1'b0;
    saw_irq_low = 1'b0;
    while (!hit && n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pulse && n == 1) strobe = 1'b0;
      if (!irq_n) saw_irq_low = 1'b1;
      case (what)
        0: hit = !irq_n;
        1: hit = irq_n;
        2: hit = !rst_out_n;
        default: hit = rst_out_n;
      endcase
    end
    if (!hit) n = -1;
  endtask

  task automatic setup(input logic [2:0] w, input logic [1:0] l, input logic [1:0] r);
    @(negedge clk);
    init = 1'b1;
    wd_code = w;
    ld_code = l;
    rw_code = r;
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R12 reset irq_n", irq_n, 1);
    chk("R12 reset rst_out_n", rst_out_n, 1);
    chk("R12 reset wd_flag", wd_flag, 0);
  endtask

  task automatic t_watchdog;
    int n;
    setup(3'b001, 2'b00, 2'b00);
    strobe = 1'b1;
    count_until(0, 2000, 1'b1, n);
    chk("R2 irq edge after strobe", n, 400 + LAT);
    chk("R2 flag set", wd_flag, 1);
    repeat (100) @(negedge clk);
    chk("R3 irq held low", irq_n, 0);
    strobe = 1'b1;
    count_until(1, 50, 1'b1, n);
    chk("R1 strobe clears irq", n, LAT);
    chk("R4 flag kept", wd_flag, 1);
    count_until(0, 2000, 1'b0, n);
    chk("R1 restart from zero", n, 400);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R4 flag cleared", wd_flag, 0);
  endtask

  task automatic t_free_run;
    int n;
    setup(3'b001, 2'b01, 2'b00);
    count_until(0, 2000, 1'b0, n);
    chk("R2 irq after init", n, 400);
    count_until(2, 3000, 1'b0, n);
    chk("R5 reset at 1600", n, 1200);
    chk("R3 reset clears irq", irq_n, 1);
    count_until(3, 500, 1'b0, n);
    chk("R6 width code 00", n, 25);
    count_until(0, 2000, 1'b0, n);
    chk("R7 irq after reset end", n, 400);
    count_until(2, 3000, 1'b0, n);
    chk("R7 second reset", n, 1200);
  endtask

  task automatic t_width;
    int n;
    setup(3'b000, 2'b01, 2'b11);
    count_until(2, 3000, 1'b0, n);
    chk("R5 reset code 01", n, 1600);
    count_until(3, 500, 1'b0, n);
    chk("R6 width code 11", n, 200);
    count_until(2, 3000, 1'b0, n);
    chk("R7 reset again", n, 1600);
    repeat (10) @(negedge clk);
    strobe = 1'b1;
    count_until(3, 500, 1'b1, n);
    chk("R6 strobe ends reset", n, LAT);
    count_until(2, 3000, 1'b0, n);
    chk("R7 restart after early end", n, 1600);
  endtask

  task automatic t_equal;
    int n;
    bit any_low;
    setup(3'b011, 2'b01, 2'b00);
    count_until(2, 3000, 1'b0, n);
    any_low = saw_irq_low;
    chk("R8 reset at 1600", n, 1600);
    count_until(3, 500, 1'b0, n);
    any_low = any_low | saw_irq_low;
    count_until(2, 3000, 1'b0, n);
    any_low = any_low | saw_irq_low;
    chk("R8 irq never low", any_low, 0);
    chk("R8 flag clear", wd_flag, 0);
  endtask

  task automatic t_strobe_high;
    int n;
    setup(3'b001, 2'b01, 2'b00);
    strobe = 1'b1;
    count_until(2, 3000, 1'b0, n);
    chk("R9 reset still fires", n, 1600 + LAT);
    chk("R9 irq masked", saw_irq_low, 0);
    chk("R9 flag masked", wd_flag, 0);
    strobe = 1'b0;
  endtask

  task automatic t_off_codes;
    int n;
    setup(3'b110, 2'b00, 2'b00);
    count_until(0, 7000, 1'b0, n);
    chk("R10 code 110 off", n, -1);
    setup(3'b111, 2'b00, 2'b00);
    count_until(2, 7000, 1'b0, n);
    chk("R10 code 111 off", saw_irq_low, 0);
    chk("R5 code 00 disabled", n, -1);
    setup(3'b101, 2'b00, 2'b00);
    count_until(0, 7000, 1'b0, n);
    chk("R2 code 101 period", n, 6400);
  endtask

  task automatic t_tick;
    int n;
    tick = 1'b0;
    setup(3'b001, 2'b00, 2'b00);
    count_until(0, 1000, 1'b0, n);
    chk("R11 no tick no timeout", n, -1);
    tick = 1'b1;
    count_until(0, 2000, 1'b0, n);
    chk("R11 ticks resume", n, 400);
  endtask

  task automatic t_init;
    int n;
    setup(3'b000, 2'b01, 2'b00);
    count_until(2, 3000, 1'b0, n);
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R12 init ends reset", rst_out_n, 1);
    chk("R12 init irq high", irq_n, 1);
    count_until(2, 3000, 1'b0, n);
    chk("R12 count restarted", n, 1600);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_watchdog();
    t_free_run();
    t_width();
    t_equal();
    t_strobe_high();
    t_off_codes();
    t_tick();
    t_init();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule